// File: doc/BRIEF.md
# PHY Register Access Handshake Port

This block lets software reach a small bank of PHY configuration registers through a single 32-bit host register. Software first loads a 6-bit PHY address and an 8-bit write value. It then sets either the write strobe or the read strobe and leaves it high. The port turns the rising strobe into one transaction on an internal PHY bus and sets a sticky acknowledge flag when the PHY answers. Software clears the strobe once it sees the acknowledge, and the port then clears the acknowledge. This gives a four-phase handshake through one shared register.

A read places the addressed PHY byte in a read-only byte field of the host register, at the same time as the acknowledge appears. A behavioural PHY register file with a parameterised response latency is part of the block. It holds 64 bytes that reset to zero. The low addresses of that file carry the per-speed input delays, and addresses 0x0B to 0x0D carry the clock and strobe delay-line settings.

Top module: `phy_access_port`

## Requirements
- R1: The access register answers only at host byte offset 0x10 (parameter `REG_OFFSET`). A read at any other offset returns zero, and a write at any other offset changes nothing.
- R2: Field layout of the access register: PHY address in bits 5:0, write byte in bits 15:8, read byte in bits 23:16, write strobe at bit 24, read strobe at bit 25, acknowledge at bit 26. The read byte and the acknowledge ignore host writes. Bits 31:27 and 7:6 read as zero and ignore writes.
- R3: A strobe that goes from low to high launches exactly one PHY transaction. Rewriting the register while the strobe stays high, even with a new address, launches nothing more.
- R4: The acknowledge reads 1 from exactly `PHY_LATENCY`+2 clock edges after the edge that captures the strobe. It stays 1 for as long as the strobe stays high.
- R5: The acknowledge reads 0 one clock edge after the edge that captures the cleared strobe. The port is then ready for the next access.
- R6: A read access loads the addressed PHY byte into bits 23:16 no later than the edge on which the acknowledge rises. A write access leaves bits 23:16 unchanged.
- R7: A write access stores the write byte at the addressed PHY register, and a later read of that address returns it. All 64 addresses are implemented.
- R8: Setting both strobes together is illegal. It launches no transaction, raises no acknowledge, and changes neither the PHY registers nor the read byte, until both strobes are cleared.
- R9: After reset the access register reads 0x00000000 and every PHY register holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Host write enable for this cycle |
| bus_addr | input | BUS_AW | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational on `bus_addr` |

## Verification
A host write that sets a strobe is captured on one edge. The acknowledge, and for a read the read byte, must appear together exactly `PHY_LATENCY`+2 edges later. After the edge that captures a cleared strobe, the acknowledge must drop on the next edge. The driver records the cycle of every strobe write together with the byte it expects. The monitor samples the register on falling edges and compares each acknowledge rise against the oldest queued item, including the exact cycle. Checks that expect nothing to happen (illegal strobes, foreign offsets, ignored fields) wait many cycles past the acknowledge latency before they sample the register.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;
   localparam int HOST_W    = 32;
   localparam int PHY_AW    = 6;
   localparam int PHY_DW    = 8;
   localparam int PHY_REGS  = 1 << PHY_AW;
   // field positions inside the host access register
   localparam int F_ADDR_LSB  = 0;
   localparam int F_WDAT_LSB  = 8;
   localparam int F_RDAT_LSB  = 16;
   localparam int F_WSTB_BIT  = 24;
   localparam int F_RSTB_BIT  = 25;
   localparam int F_ACK_BIT   = 26;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_BUSY  = 2'd1,
      SQ_DONE  = 2'd2,
      SQ_BLOCK = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic              we;
      logic [PHY_AW-1:0] addr;
      logic [PHY_DW-1:0] wdata;
   } phy_req_t;
endpackage

// File: rtl/phyacc_hostreg.sv
module phyacc_hostreg
   import phyacc_pkg::*;
#(
   parameter int BUS_AW     = 12,
   parameter int REG_OFFSET = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [HOST_W-1:0] bus_wdata,
   output logic [HOST_W-1:0] bus_rdata,
   input  logic              ack_i,
   input  logic              cap_i,
   input  logic [PHY_DW-1:0] cap_data_i,
   output logic              stb_wr_o,
   output logic              stb_rd_o,
   output logic [PHY_AW-1:0] addr_o,
   output logic [PHY_DW-1:0] wdata_o
);
   localparam logic [BUS_AW-1:0] OFF_L = REG_OFFSET[BUS_AW-1:0];

   if (REG_OFFSET < 0 || REG_OFFSET >= (1 << BUS_AW) || (REG_OFFSET % 4) != 0) begin : g_bad_offset
      $error("REG_OFFSET must be word aligned and inside the host address space");
   end

   logic              hit;
   logic [PHY_AW-1:0] addr_q;
   logic [PHY_DW-1:0] wdat_q;
   logic [PHY_DW-1:0] rdat_q;
   logic              wstb_q;
   logic              rstb_q;
   logic [HOST_W-1:0] view;
   logic              unused_bits;

   assign hit         = (bus_addr == OFF_L);
   assign unused_bits = ^{bus_wdata[31:27], bus_wdata[26], bus_wdata[23:16], bus_wdata[7:6]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wdat_q <= '0;
         wstb_q <= 1'b0;
         rstb_q <= 1'b0;
      end else if (bus_we && hit) begin
         addr_q <= bus_wdata[F_ADDR_LSB +: PHY_AW];
         wdat_q <= bus_wdata[F_WDAT_LSB +: PHY_DW];
         wstb_q <= bus_wdata[F_WSTB_BIT];
         rstb_q <= bus_wdata[F_RSTB_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
      end else if (cap_i) begin
         rdat_q <= cap_data_i;
      end
   end

   always_comb begin
      view                          = '0;
      view[F_ADDR_LSB +: PHY_AW]    = addr_q;
      view[F_WDAT_LSB +: PHY_DW]    = wdat_q;
      view[F_RDAT_LSB +: PHY_DW]    = rdat_q;
      view[F_WSTB_BIT]              = wstb_q;
      view[F_RSTB_BIT]              = rstb_q;
      view[F_ACK_BIT]               = ack_i;
   end

   assign bus_rdata = hit ? view : '0;
   assign stb_wr_o  = wstb_q;
   assign stb_rd_o  = rstb_q;
   assign addr_o    = addr_q;
   assign wdata_o   = wdat_q;

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(rdat_q)); // R6
   AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && hit) |=> $stable({addr_q, wdat_q, wstb_q, rstb_q})); // R1
endmodule

// File: rtl/phyacc_seq.sv
module phyacc_seq
   import phyacc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_wr_i,
   input  logic              stb_rd_i,
   input  logic [PHY_AW-1:0] addr_i,
   input  logic [PHY_DW-1:0] wdata_i,
   output logic              req_valid_o,
   output phy_req_t          req_o,
   input  logic              rsp_valid_i,
   input  logic [PHY_DW-1:0] rsp_data_i,
   output logic              ack_o,
   output logic              cap_o,
   output logic [PHY_DW-1:0] cap_data_o
);
   seq_state_e state_q;
   logic       req_q;
   phy_req_t   pkt_q;
   logic       ack_q;
   logic       any_stb;
   logic       one_stb;

   assign any_stb = stb_wr_i | stb_rd_i;
   assign one_stb = stb_wr_i ^ stb_rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         req_q   <= 1'b0;
         pkt_q   <= '0;
         ack_q   <= 1'b0;
      end else begin
         req_q <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (one_stb) begin
                  req_q   <= 1'b1;
                  pkt_q   <= '{we: stb_wr_i, addr: addr_i, wdata: wdata_i};
                  state_q <= SQ_BUSY;
               end else if (any_stb) begin
                  state_q <= SQ_BLOCK;
               end
            end
            SQ_BUSY: begin
               if (rsp_valid_i) begin
                  ack_q   <= 1'b1;
                  state_q <= SQ_DONE;
               end
            end
            SQ_DONE: begin
               if (!any_stb) begin
                  ack_q   <= 1'b0;
                  state_q <= SQ_IDLE;
               end
            end
            SQ_BLOCK: begin
               if (!any_stb) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign req_valid_o = req_q;
   assign req_o       = pkt_q;
   assign ack_o       = ack_q;
   assign cap_o       = (state_q == SQ_BUSY) && rsp_valid_i && !pkt_q.we;
   assign cap_data_o  = rsp_data_i;

   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && any_stb) |=> ack_o); // R4
   AST_ACK_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(rsp_valid_i)); // R4
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !any_stb) |=> !ack_o); // R5
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |=> !req_valid_o); // R3
   AST_REQ_SINGLE_STB: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> $past(stb_wr_i ^ stb_rd_i)); // R8
endmodule

// File: rtl/phyacc_phy_model.sv
module phyacc_phy_model
   import phyacc_pkg::*;
#(
   parameter int LATENCY     = 3,
   parameter int MAX_LATENCY = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  phy_req_t          req_i,
   output logic              rsp_valid_o,
   output logic [PHY_DW-1:0] rsp_data_o
);
   if (LATENCY < 1 || LATENCY > MAX_LATENCY) begin : g_bad_latency
      $error("LATENCY must lie between 1 and MAX_LATENCY");
   end

   logic [PHY_DW-1:0] mem_q [PHY_REGS];
   logic              rsp_q;
   logic [PHY_DW-1:0] rdat_q;

   if (LATENCY == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < PHY_REGS; i++) mem_q[i] <= '0;
            rsp_q  <= 1'b0;
            rdat_q <= '0;
         end else begin
            rsp_q <= 1'b0;
            if (req_valid_i) begin
               rsp_q  <= 1'b1;
               rdat_q <= mem_q[req_i.addr];
               if (req_i.we) mem_q[req_i.addr] <= req_i.wdata;
            end
         end
      end
   end else begin : g_delayed
      localparam int CNT_W = $clog2(LATENCY + 1);
      logic [CNT_W-1:0] cnt_q;
      logic             pend_q;
      phy_req_t         hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < PHY_REGS; i++) mem_q[i] <= '0;
            rsp_q  <= 1'b0;
            rdat_q <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            hold_q <= '0;
         end else begin
            rsp_q <= 1'b0;
            if (req_valid_i) begin
               pend_q <= 1'b1;
               cnt_q  <= CNT_W'(LATENCY - 1);
               hold_q <= req_i;
            end else if (pend_q) begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) begin
                  pend_q <= 1'b0;
                  rsp_q  <= 1'b1;
                  rdat_q <= mem_q[hold_q.addr];
                  if (hold_q.we) mem_q[hold_q.addr] <= hold_q.wdata;
               end
            end
         end
      end

      AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid_i |-> !pend_q); // R3
   end

   assign rsp_valid_o = rsp_q;
   assign rsp_data_o  = rdat_q;
endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
   import phyacc_pkg::*;
#(
   parameter int BUS_AW      = 12,
   parameter int REG_OFFSET  = 16,
   parameter int PHY_LATENCY = 3,
   parameter int MAX_LATENCY = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   logic              stb_wr;
   logic              stb_rd;
   logic [PHY_AW-1:0] reg_addr;
   logic [PHY_DW-1:0] reg_wdat;
   logic              ack;
   logic              cap;
   logic [PHY_DW-1:0] cap_data;
   logic              req_valid;
   phy_req_t          req;
   logic              rsp_valid;
   logic [PHY_DW-1:0] rsp_data;

   phyacc_hostreg #(
      .BUS_AW     (BUS_AW),
      .REG_OFFSET (REG_OFFSET)
   ) i_hostreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ack_i      (ack),
      .cap_i      (cap),
      .cap_data_i (cap_data),
      .stb_wr_o   (stb_wr),
      .stb_rd_o   (stb_rd),
      .addr_o     (reg_addr),
      .wdata_o    (reg_wdat)
   );

   phyacc_seq i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb_wr_i    (stb_wr),
      .stb_rd_i    (stb_rd),
      .addr_i      (reg_addr),
      .wdata_i     (reg_wdat),
      .req_valid_o (req_valid),
      .req_o       (req),
      .rsp_valid_i (rsp_valid),
      .rsp_data_i  (rsp_data),
      .ack_o       (ack),
      .cap_o       (cap),
      .cap_data_o  (cap_data)
   );

   phyacc_phy_model #(
      .LATENCY     (PHY_LATENCY),
      .MAX_LATENCY (MAX_LATENCY)
   ) i_phy (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid),
      .req_i       (req),
      .rsp_valid_o (rsp_valid),
      .rsp_data_o  (rsp_data)
   );
endmodule

// File: tb/test_phy_access_port.sv
`timescale 1ns/1ps
module test_phy_access_port;
   localparam int AW  = 12;
   localparam int OFF = 16;
   localparam int LAT = 3;

   typedef struct {
      int          due;
      logic [7:0]  rd;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = AW'(OFF);
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   exp_t sbq[$];
   logic [7:0] model_mem [64];
   logic [7:0] last_rd = '0;
   logic       ack_prev = 1'b0;
   logic [31:0] mon_v;
   exp_t        mon_e;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   phy_access_port #(
      .BUS_AW      (AW),
      .REG_OFFSET  (OFF),
      .PHY_LATENCY (LAT)
   ) i_phy_access_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   function automatic logic [31:0] mk(input logic [5:0] a, input logic [7:0] wd,
                                      input bit ws, input bit rs);
      return 32'(a) | (32'(wd) << 8) | (32'(ws) << 24) | (32'(rs) << 25);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   // monitor: each acknowledge rise must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && bus_addr == AW'(OFF)) begin
         mon_v = bus_rdata;
         if (mon_v[26] && !ack_prev) begin
            if (sbq.size() == 0) begin
               chk(1'b0, "R3 unexpected acknowledge", mon_v, 32'h0);
            end else begin
               mon_e = sbq.pop_front();
               chk(cyc == mon_e.due, {mon_e.tag, " R4 ack cycle"}, cyc, mon_e.due);
               chk(mon_v[23:16] == mon_e.rd, {mon_e.tag, " R6 read byte"}, 32'(mon_v[23:16]), 32'(mon_e.rd));
            end
         end
         ack_prev = mon_v[26];
      end
   end

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0; bus_addr = AW'(OFF);
   endtask

   task automatic wait_ack();
      int n = 0;
      do begin @(negedge clk); n++; end while (!bus_rdata[26] && n < 100);
   endtask

   // strobe write whose acknowledge the monitor checks; returns once the edge has captured it
   task automatic launch(input bit rd, input logic [5:0] a, input logic [7:0] d, input string tag);
      exp_t it;
      int   c;
      bus_write(AW'(OFF), mk(a, d, 1'b0, 1'b0));
      @(posedge clk); #1;
      c = cyc;
      bus_we = 1'b1; bus_wdata = mk(a, d, !rd, rd);
      if (rd) last_rd = model_mem[a];
      else    model_mem[a] = d;
      it.due = c + LAT + 3; it.rd = last_rd; it.tag = tag;
      sbq.push_back(it);
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic access(input bit rd, input logic [5:0] a, input logic [7:0] d, input string tag);
      launch(rd, a, d, tag);
      wait_ack();
      bus_write(AW'(OFF), mk(a, d, 1'b0, 1'b0));
      @(posedge clk); @(negedge clk);
      chk(bus_rdata[26] == 1'b0, {tag, " R5 ack clears"}, 32'(bus_rdata[26]), 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model_mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(bus_rdata == 32'h0, "R9 register after reset", bus_rdata, 32'h0);

      access(1'b1, 6'h05, 8'h00, "R9 PHY zero after reset");

      access(1'b0, 6'h00, 8'h11, "R7 write 0x00");
      access(1'b0, 6'h0B, 8'h5A, "R7 write 0x0B");
      access(1'b0, 6'h0D, 8'hC3, "R7 write 0x0D");
      access(1'b0, 6'h3F, 8'hFF, "R7 write 0x3F");
      access(1'b0, 6'h08, 8'h80, "R7 write 0x08");
      access(1'b1, 6'h0D, 8'h00, "R7 read 0x0D");
      access(1'b1, 6'h00, 8'h00, "R7 read 0x00");
      access(1'b1, 6'h3F, 8'h00, "R7 read 0x3F");
      access(1'b0, 6'h0B, 8'h6B, "R6 write keeps read byte");
      access(1'b1, 6'h08, 8'h00, "R7 read 0x08");

      // R3/R4: strobe held high, register rewritten with a new address
      launch(1'b1, 6'h0B, 8'h00, "R3 held read");
      wait_ack();
      bus_write(AW'(OFF), mk(6'h0D, 8'h00, 1'b0, 1'b1));
      repeat (12) @(negedge clk);
      chk(bus_rdata == (mk(6'h0D, 8'h00, 1'b0, 1'b1) | 32'h0400_0000 | (32'(last_rd) << 16)),
          "R3 R4 no relaunch, ack held", bus_rdata,
          mk(6'h0D, 8'h00, 1'b0, 1'b1) | 32'h0400_0000 | (32'(last_rd) << 16));
      bus_write(AW'(OFF), mk(6'h0D, 8'h00, 1'b0, 1'b0));
      @(posedge clk); @(negedge clk);
      chk(bus_rdata[26] == 1'b0, "R5 ack clears after held read", 32'(bus_rdata[26]), 32'h0);

      // R8: both strobes
      bus_write(AW'(OFF), mk(6'h00, 8'h77, 1'b1, 1'b1));
      repeat (20) @(negedge clk);
      chk(bus_rdata == (mk(6'h00, 8'h77, 1'b1, 1'b1) | (32'(last_rd) << 16)),
          "R8 no ack for both strobes", bus_rdata, mk(6'h00, 8'h77, 1'b1, 1'b1) | (32'(last_rd) << 16));
      bus_write(AW'(OFF), mk(6'h00, 8'h00, 1'b0, 1'b0));
      access(1'b1, 6'h00, 8'h00, "R8 PHY unchanged after illegal strobes");

      // R2: ignored and read-only fields
      bus_write(AW'(OFF), 32'hF8FF_ABFF);
      @(negedge clk);
      chk(bus_rdata == ((32'(last_rd) << 16) | 32'h0000_AB3F), "R2 reserved bits read zero",
          bus_rdata, (32'(last_rd) << 16) | 32'h0000_AB3F);
      bus_write(AW'(OFF), 32'h0400_0000);
      repeat (10) @(negedge clk);
      chk(bus_rdata == (32'(last_rd) << 16), "R2 ack not writable", bus_rdata, 32'(last_rd) << 16);

      // R1: other offsets
      @(posedge clk); #1 bus_addr = AW'(16'h014);
      @(negedge clk);
      chk(bus_rdata == 32'h0, "R1 offset 0x14 reads zero", bus_rdata, 32'h0);
      @(posedge clk); #1 bus_addr = AW'(16'h810);
      @(negedge clk);
      chk(bus_rdata == 32'h0, "R1 offset 0x810 reads zero", bus_rdata, 32'h0);
      bus_write(AW'(16'h014), mk(6'h05, 8'h99, 1'b1, 1'b0));
      repeat (10) @(negedge clk);
      chk(bus_rdata == (32'(last_rd) << 16), "R1 foreign write ignored", bus_rdata, 32'(last_rd) << 16);
      access(1'b1, 6'h05, 8'h00, "R1 PHY untouched by foreign write");

      repeat (4) @(negedge clk);
      chk(sbq.size() == 0, "R3 every access acknowledged", sbq.size(), 32'h0);
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
   end
endmodule